// File: doc/BRIEF.md
# Parallel Bulk-Erase Controller

This controller runs the full bulk-erase flow on a group of byte-wide flash devices that share one address and data bus, each device having its own active-low chip enable. Once started, it first asks an external program sequencer to write 00h into every byte of every device. It then loops. Each pass sends one erase pulse to the devices that have not yet passed, and then checks each of those devices byte by byte with the erase-verify command.

A device that reads back FFh on all of its bytes is masked. From then on its chip enable stays high during every later erase pulse. A device that fails a byte keeps its verify pointer, so the next pass resumes at the byte that failed. When every device has passed, or the pulse budget is spent, the controller writes the read command to all devices and raises done, with fail showing which way the run ended.

Both outgoing request channels use valid/ready. Once the controller raises valid, it holds every field of the request stable until ready is seen high on a clock edge. The downstream side may hold ready low for any number of cycles. Read data comes back on a valid-only return channel: the controller waits in the read state for it and ignores it at any other time. The timed waits after an erase pulse and after a verify command are parameters in clock cycles.

Top module: `flash_par_erase`

## Requirements
- R1: After reset, done, fail and pass_mask are 0, and neither bus_valid nor pgm_valid is asserted.
- R2: After start, one program request is issued for every byte of every device before any bus request. The order is device index ascending, and byte address ascending within each device.
- R3: Each erase pulse is two bus writes of data 20h. In both writes bus_ce_n is high exactly for the devices already in pass_mask. After the second write, no bus request is accepted for more than ERASE_WAIT_CYC cycles.
- R4: The verify of a byte is a write of A0h to that byte address with only that device's chip enable low. It is followed, more than VERIFY_WAIT_CYC cycles later, by a read request (bus_we = 0) of the same address on the same device.
- R5: When a verify read returns FFh on the last byte (N_BYTES-1), that device's pass_mask bit is set. The bit stays set for the rest of the run, and that device gets no further erase or verify requests.
- R6: A verify read that returns anything other than FFh ends that device's checks for the current pass. The next pass resumes that device at the same byte address. A read of FFh on any other byte moves on to the next address.
- R7: After every erase pulse, each device not yet in pass_mask is checked, in ascending device index order.
- R8: When all devices pass, the controller writes 00h with all chip enables low. It then holds done = 1 and fail = 0, with no requests, until the next start.
- R9: If devices are still unmasked after MAX_PULSES erase pulses, the controller writes 00h with all chip enables low. It then holds done = 1 and fail = 1, with pass_mask showing the devices that passed.
- R10: While a request has valid high and ready low, it stays valid and its fields do not change.
- R11: A start pulse received while a run is in progress has no effect on the request sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle or done) |
| pgm_valid | output | 1 | Program-to-00h request valid |
| pgm_ready | input | 1 | Program sequencer accepts and completes the byte |
| pgm_dev | output | DW | Device index to program |
| pgm_addr | output | AW | Byte address to program |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted |
| bus_we | output | 1 | 1 = command write, 0 = read |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 8 | Command byte |
| bus_ce_n | output | N_DEV | Per-device chip enable, active low (all high when idle) |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 8 | Returned byte |
| pass_mask | output | N_DEV | Devices that have fully verified as erased |
| done | output | 1 | Run finished |
| fail | output | 1 | Run ended at the pulse limit |

## Verification
The assertions assume the following about the inputs:
- bus_ready and pgm_ready may change on any cycle.
- rd_valid is raised only after a read request has been accepted, and only once for each read.
- start may arrive at any time.

The stimulus model stalls both ready signals on a fixed irregular pattern. It answers each accepted read exactly once, with a one-cycle gap. It computes each byte's value from how many erase pulses that device has received, so it never returns unrequested data. The bench also raises start once in the middle of a run, to exercise the rule that start is ignored while a run is busy.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_EVERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREPROG,
    ST_ERASE_A,
    ST_ERASE_B,
    ST_ERASE_WAIT,
    ST_PICK,
    ST_VCMD,
    ST_VWAIT,
    ST_VREAD,
    ST_VRESP,
    ST_JUDGE,
    ST_FINAL,
    ST_DONE
  } state_t;
endpackage

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fpe_dev_track.sv
module fpe_dev_track #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DW-1:0]    sel,
  input  logic             adv,
  input  logic             pass,
  input  logic [DW:0]      from_idx,
  output logic [N_DEV-1:0] mask,
  output logic [AW-1:0]    sel_addr,
  output logic             found,
  output logic [DW-1:0]    next_idx
);
  logic [AW-1:0] vaddr_w [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic          m;
    logic [AW-1:0] va;
    logic          hit;

    assign hit = (sel == DW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m  <= 1'b0;
        va <= '0;
      end else if (clear) begin
        m  <= 1'b0;
        va <= '0;
      end else if (hit) begin
        if (pass) m  <= 1'b1;
        if (adv)  va <= va + 1'b1;
      end
    end

    assign mask[g]    = m;
    assign vaddr_w[g] = va;
  end

  assign sel_addr = vaddr_w[sel];

  // lowest unmasked device at or above from_idx
  always_comb begin
    found    = 1'b0;
    next_idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (!mask[i] && ((DW+1)'(i) >= from_idx)) begin
        found    = 1'b1;
        next_idx = DW'(i);
      end
    end
  end
endmodule

// File: rtl/fpe_fsm.sv
module fpe_fsm
  import fpe_pkg::*;
#(
  parameter int unsigned N_DEV           = 4,
  parameter int unsigned N_BYTES         = 256,
  parameter int unsigned MAX_PULSES      = 1000,
  parameter int unsigned ERASE_WAIT_CYC  = 1000000,
  parameter int unsigned VERIFY_WAIT_CYC = 600,
  parameter int unsigned DW              = 2,
  parameter int unsigned AW              = 8,
  parameter int unsigned TW              = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             pgm_valid,
  input  logic             pgm_ready,
  output logic [DW-1:0]    pgm_dev,
  output logic [AW-1:0]    pgm_addr,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [7:0]       bus_wdata,
  output logic [N_DEV-1:0] bus_ce_n,
  input  logic             rd_valid,
  input  logic [7:0]       rd_data,
  output logic             done,
  output logic             fail,
  input  logic [N_DEV-1:0] mask,
  input  logic [AW-1:0]    sel_addr,
  input  logic             found,
  input  logic [DW-1:0]    next_idx,
  output logic             trk_clear,
  output logic [DW-1:0]    trk_sel,
  output logic             trk_adv,
  output logic             trk_pass,
  output logic [DW:0]      scan_idx,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  input  logic             tmr_busy
);
  localparam int unsigned PCW = $clog2(MAX_PULSES + 1);

  state_t           state;
  logic [DW-1:0]    cur;
  logic [DW:0]      scan;
  logic [DW-1:0]    pg_dev;
  logic [AW-1:0]    pg_addr;
  logic [PCW-1:0]   pulses;
  logic             fail_pend;
  logic             rd_ok;
  logic             at_last;
  logic             start_ok;
  logic [N_DEV-1:0] dev_bit;

  assign rd_ok    = (rd_data == BYTE_ERASED);
  assign at_last  = (sel_addr == AW'(N_BYTES - 1));
  assign start_ok = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign dev_bit  = N_DEV'(1) << cur;

  assign trk_clear = start_ok;
  assign trk_sel   = cur;
  assign scan_idx  = scan;
  assign trk_adv   = (state == ST_VRESP) && rd_valid && rd_ok && !at_last;
  assign trk_pass  = (state == ST_VRESP) && rd_valid && rd_ok && at_last;
  assign tmr_load  = ((state == ST_ERASE_B) || (state == ST_VCMD)) && bus_ready;
  assign tmr_val   = (state == ST_ERASE_B) ? TW'(ERASE_WAIT_CYC) : TW'(VERIFY_WAIT_CYC);

  assign pgm_valid = (state == ST_PREPROG);
  assign pgm_dev   = pg_dev;
  assign pgm_addr  = pg_addr;
  assign done      = (state == ST_DONE);
  assign fail      = (state == ST_DONE) && fail_pend;

  always_comb begin
    bus_valid = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_ce_n  = '1;
    case (state)
      ST_ERASE_A, ST_ERASE_B: begin
        bus_valid = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = CMD_ERASE;
        bus_ce_n  = mask;
      end
      ST_VCMD: begin
        bus_valid = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = CMD_EVERIFY;
        bus_addr  = sel_addr;
        bus_ce_n  = ~dev_bit;
      end
      ST_VREAD: begin
        bus_valid = 1'b1;
        bus_addr  = sel_addr;
        bus_ce_n  = ~dev_bit;
      end
      ST_FINAL: begin
        bus_valid = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = CMD_READ;
        bus_ce_n  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      scan      <= '0;
      pg_dev    <= '0;
      pg_addr   <= '0;
      pulses    <= '0;
      fail_pend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            pg_dev    <= '0;
            pg_addr   <= '0;
            pulses    <= '0;
            fail_pend <= 1'b0;
            state     <= ST_PREPROG;
          end
        end
        ST_PREPROG: begin
          if (pgm_ready) begin
            if (pg_addr == AW'(N_BYTES - 1)) begin
              pg_addr <= '0;
              if (pg_dev == DW'(N_DEV - 1)) state <= ST_ERASE_A;
              else                          pg_dev <= pg_dev + 1'b1;
            end else begin
              pg_addr <= pg_addr + 1'b1;
            end
          end
        end
        ST_ERASE_A: if (bus_ready) state <= ST_ERASE_B;
        ST_ERASE_B: begin
          if (bus_ready) begin
            pulses <= pulses + 1'b1;
            state  <= ST_ERASE_WAIT;
          end
        end
        ST_ERASE_WAIT: begin
          if (!tmr_busy) begin
            scan  <= '0;
            state <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (found) begin
            cur   <= next_idx;
            state <= ST_VCMD;
          end else begin
            state <= ST_JUDGE;
          end
        end
        ST_VCMD:  if (bus_ready) state <= ST_VWAIT;
        ST_VWAIT: if (!tmr_busy) state <= ST_VREAD;
        ST_VREAD: if (bus_ready) state <= ST_VRESP;
        ST_VRESP: begin
          if (rd_valid) begin
            if (rd_ok && !at_last) begin
              state <= ST_VCMD;
            end else begin
              scan  <= (DW+1)'(cur) + 1'b1;
              state <= ST_PICK;
            end
          end
        end
        ST_JUDGE: begin
          if (&mask) begin
            state <= ST_FINAL;
          end else if (pulses == PCW'(MAX_PULSES)) begin
            fail_pend <= 1'b1;
            state     <= ST_FINAL;
          end else begin
            state <= ST_ERASE_A;
          end
        end
        ST_FINAL: if (bus_ready) state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_par_erase.sv
module flash_par_erase #(
  parameter int unsigned N_DEV           = 4,
  parameter int unsigned N_BYTES         = 256,
  parameter int unsigned MAX_PULSES      = 1000,
  parameter int unsigned ERASE_WAIT_CYC  = 1000000,
  parameter int unsigned VERIFY_WAIT_CYC = 600,
  localparam int unsigned DW   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int unsigned AW   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int unsigned TMAX = (ERASE_WAIT_CYC > VERIFY_WAIT_CYC) ? ERASE_WAIT_CYC : VERIFY_WAIT_CYC,
  localparam int unsigned TW   = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             pgm_valid,
  input  logic             pgm_ready,
  output logic [DW-1:0]    pgm_dev,
  output logic [AW-1:0]    pgm_addr,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [7:0]       bus_wdata,
  output logic [N_DEV-1:0] bus_ce_n,
  input  logic             rd_valid,
  input  logic [7:0]       rd_data,
  output logic [N_DEV-1:0] pass_mask,
  output logic             done,
  output logic             fail
);
  logic          trk_clear, trk_adv, trk_pass, found, tmr_load, tmr_busy;
  logic [DW-1:0] trk_sel, next_idx;
  logic [DW:0]   scan_idx;
  logic [AW-1:0] sel_addr;
  logic [TW-1:0] tmr_val;

  fpe_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(tmr_busy)
  );

  fpe_dev_track #(.N_DEV(N_DEV), .AW(AW), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(trk_clear), .sel(trk_sel), .adv(trk_adv),
    .pass(trk_pass), .from_idx(scan_idx), .mask(pass_mask), .sel_addr(sel_addr),
    .found(found), .next_idx(next_idx)
  );

  fpe_fsm #(
    .N_DEV(N_DEV), .N_BYTES(N_BYTES), .MAX_PULSES(MAX_PULSES),
    .ERASE_WAIT_CYC(ERASE_WAIT_CYC), .VERIFY_WAIT_CYC(VERIFY_WAIT_CYC),
    .DW(DW), .AW(AW), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pgm_valid(pgm_valid), .pgm_ready(pgm_ready), .pgm_dev(pgm_dev), .pgm_addr(pgm_addr),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ce_n(bus_ce_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .fail(fail), .mask(pass_mask), .sel_addr(sel_addr), .found(found),
    .next_idx(next_idx), .trk_clear(trk_clear), .trk_sel(trk_sel), .trk_adv(trk_adv),
    .trk_pass(trk_pass), .scan_idx(scan_idx), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tmr_busy(tmr_busy)
  );
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned N_BYTES = 256,
  localparam int unsigned DW = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int unsigned AW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pgm_valid,
  input logic             pgm_ready,
  input logic [DW-1:0]    pgm_dev,
  input logic [AW-1:0]    pgm_addr,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [N_DEV-1:0] bus_ce_n,
  input logic [N_DEV-1:0] pass_mask,
  input logic             done,
  input logic             fail
);
  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) && $stable(bus_addr)
                                && $stable(bus_wdata) && $stable(bus_ce_n));

  assert_pgm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid && !pgm_ready |=> pgm_valid && $stable(pgm_dev) && $stable(pgm_addr));

  assert_masked_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_we && (bus_wdata == 8'h20) |-> ((bus_ce_n & pass_mask) == pass_mask));

  assert_verify_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (!bus_we || (bus_wdata == 8'hA0))
      |-> ($countones(~bus_ce_n) == 1) && ((~bus_ce_n & pass_mask) == '0));

  assert_mask_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((pass_mask & $past(pass_mask)) == $past(pass_mask)));

  assert_fail_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && !pgm_valid);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> !bus_valid);
endmodule

bind flash_par_erase fpe_checker #(.N_DEV(N_DEV), .N_BYTES(N_BYTES)) u_chk (.*);

// File: tb/flash_par_erase_tb.sv
module flash_par_erase_tb;
  localparam int ND = 3;
  localparam int NB = 4;
  localparam int MP = 4;
  localparam int EW = 20;
  localparam int VW = 5;

  typedef struct packed {
    logic [1:0] kind;   // 0 program, 1 write, 2 read
    logic [7:0] data;
    logic [7:0] addr;
    logic [7:0] cen;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pgm_valid, pgm_ready;
  logic [1:0] pgm_dev;
  logic [1:0] pgm_addr;
  logic bus_valid, bus_ready, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [ND-1:0] bus_ce_n;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [ND-1:0] pass_mask;
  logic done, fail;

  always #5 clk = ~clk;

  flash_par_erase #(.N_DEV(ND), .N_BYTES(NB), .MAX_PULSES(MP),
                    .ERASE_WAIT_CYC(EW), .VERIFY_WAIT_CYC(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pgm_valid(pgm_valid), .pgm_ready(pgm_ready), .pgm_dev(pgm_dev), .pgm_addr(pgm_addr),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ce_n(bus_ce_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .pass_mask(pass_mask), .done(done), .fail(fail)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t exp_q[$];
  string tag_q[$];
  int need [ND][NB];
  int cnt20 [ND];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] d, input int a,
                      input logic [7:0] c, input string tag);
    item_t it;
    it.kind = k; it.data = d; it.addr = 8'(a); it.cen = c;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // driver: expected request stream derived from the requirements
  task automatic build_exp(output bit efail, output logic [ND-1:0] emask);
    int va [ND];
    bit m [ND];
    int p;
    bit all;
    logic [7:0] cen;
    for (int d = 0; d < ND; d++)
      for (int a = 0; a < NB; a++) push(2'd0, 8'(d), a, 8'h00, "R2");
    for (int d = 0; d < ND; d++) begin va[d] = 0; m[d] = 0; end
    p = 0;
    efail = 0;
    forever begin
      cen = 8'h00;
      for (int d = 0; d < ND; d++) cen[d] = m[d];
      push(2'd1, 8'h20, 0, cen, "R3");
      push(2'd1, 8'h20, 0, cen, "R3");
      p++;
      for (int d = 0; d < ND; d++) begin
        if (!m[d]) begin
          forever begin
            cen = 8'h00;
            for (int k = 0; k < ND; k++) cen[k] = (k != d);
            push(2'd1, 8'hA0, va[d], cen, "R4");
            push(2'd2, 8'h00, va[d], cen, "R5 R6 R7");
            if (need[d][va[d]] <= p) begin
              if (va[d] == NB - 1) begin m[d] = 1; break; end
              va[d]++;
            end else break;
          end
        end
      end
      all = 1;
      for (int d = 0; d < ND; d++) all &= m[d];
      if (all) begin efail = 0; break; end
      if (p == MP) begin efail = 1; break; end
    end
    push(2'd1, 8'h00, 0, 8'h00, "R8 R9");
    for (int d = 0; d < ND; d++) emask[d] = m[d];
  endtask

  // ready stalls and read responses
  bit rd_sched = 0;
  logic [7:0] rd_val;
  int stall = 0;
  initial begin
    bus_ready = 1'b0; pgm_ready = 1'b0; rd_valid = 1'b0; rd_data = 8'h00;
    forever begin
      @(negedge clk);
      stall++;
      bus_ready = (stall % 4) != 2;
      pgm_ready = (stall % 3) != 0;
      rd_valid = 1'b0;
      if (rd_sched) begin
        rd_valid = 1'b1;
        rd_data  = rd_val;
        rd_sched = 0;
      end
    end
  end

  // monitor: pops expected items on each accepted request
  int cyc = 0;
  int n20 = 0;
  bit e_pend = 0, v_pend = 0, h_pend = 0;
  int t_e = 0, t_v = 0;
  item_t h_item;
  initial begin
    item_t act, ex;
    string tg;
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      if (h_pend) begin
        check(bus_valid && (bus_we == h_item.kind[0]) && (8'(bus_addr) == h_item.addr)
              && (bus_wdata == h_item.data || !bus_we) && (8'(bus_ce_n) == h_item.cen),
              "R10", "stalled request changed", {31'd0, bus_valid}, 32'd1);
        h_pend = 0;
      end
      if (bus_valid && !bus_ready) begin
        h_item.kind = {1'b0, bus_we}; h_item.data = bus_wdata;
        h_item.addr = 8'(bus_addr); h_item.cen = 8'(bus_ce_n);
        h_pend = 1;
      end
      if (pgm_valid && pgm_ready) begin
        act.kind = 2'd0; act.data = 8'(pgm_dev); act.addr = 8'(pgm_addr); act.cen = 8'h00;
        if (exp_q.size() == 0) check(0, "R2", "unexpected program request", act, 0);
        else begin
          ex = exp_q.pop_front(); tg = tag_q.pop_front();
          check(act === ex, tg, "program request", act, ex);
        end
      end
      if (bus_valid && bus_ready) begin
        act.kind = bus_we ? 2'd1 : 2'd2;
        act.data = bus_we ? bus_wdata : 8'h00;
        act.addr = 8'(bus_addr);
        act.cen  = 8'(bus_ce_n);
        if (e_pend && !(bus_we && bus_wdata == 8'h20)) begin
          check((cyc - t_e) > EW, "R3", "erase wait too short", cyc - t_e, EW + 1);
          e_pend = 0;
        end
        if (v_pend && !bus_we) begin
          check((cyc - t_v) > VW, "R4", "verify wait too short", cyc - t_v, VW + 1);
          v_pend = 0;
        end
        if (bus_we && bus_wdata == 8'h20) begin
          n20++;
          for (int d = 0; d < ND; d++) if (!bus_ce_n[d]) cnt20[d]++;
          if (n20 == 2) begin e_pend = 1; t_e = cyc; n20 = 0; end
        end else n20 = 0;
        if (bus_we && bus_wdata == 8'hA0) begin v_pend = 1; t_v = cyc; end
        if (!bus_we) begin
          rd_val = 8'h7E;
          for (int d = 0; d < ND; d++)
            if (!bus_ce_n[d] && (cnt20[d] / 2 >= need[d][bus_addr])) rd_val = 8'hFF;
          rd_sched = 1;
        end
        if (exp_q.size() == 0) check(0, "R8", "unexpected bus request", act, 0);
        else begin
          ex = exp_q.pop_front(); tg = tag_q.pop_front();
          check(act === ex, tg, "bus request", act, ex);
        end
      end
    end
  end

  task automatic run_scn(input string name, input bit mid_start);
    bit efail;
    logic [ND-1:0] emask;
    exp_q.delete(); tag_q.delete();
    for (int d = 0; d < ND; d++) cnt20[d] = 0;
    build_exp(efail, emask);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done) @(negedge clk);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    #2;
    check(fail == efail, "R8 R9", {name, " fail flag"}, fail, efail);
    check(pass_mask == emask, "R5 R9", {name, " pass mask"}, pass_mask, emask);
    check(exp_q.size() == 0, mid_start ? "R11" : "R7", {name, " requests left"}, exp_q.size(), 0);
    repeat (10) @(negedge clk);
    #2;
    check(done && !bus_valid && !pgm_valid, "R8", {name, " done held quiet"},
          {bus_valid, pgm_valid, done}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!done, "R1", "done after reset", done, 0);
    check(!fail, "R1", "fail after reset", fail, 0);
    check(pass_mask == '0, "R1", "mask after reset", pass_mask, 0);
    check(!bus_valid && !pgm_valid, "R1", "requests after reset", {bus_valid, pgm_valid}, 0);
    rst_n = 1'b1;
    // all pass, devices pass after different pulse counts, one resumes mid-device
    need = '{'{1, 1, 1, 1}, '{1, 2, 1, 3}, '{2, 2, 2, 2}};
    run_scn("staggered", 1'b1);
    // one byte never erases within the budget
    need = '{'{1, 1, 1, 1}, '{1, 1, 1, 1}, '{1, 5, 1, 1}};
    run_scn("limit", 1'b0);
    // everything passes after the first pulse, started from done
    need = '{'{1, 1, 1, 1}, '{1, 1, 1, 1}, '{1, 1, 1, 1}};
    run_scn("single", 1'b0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule